// File: doc/BRIEF.md
# Receive Flow-Control Pacer with Hysteresis

This block decides when the local receiver asks its link partner to pause. It watches the fill count of a receive FIFO and drives an active-low request-to-send pin. It also raises a receive-trigger interrupt. The FIFO storage is outside the block. Only its occupancy count enters here.

A two-bit trigger select picks the interrupt level N from four parameterised levels. A two-bit hysteresis select picks how the pin thresholds are placed around N:

- **Legacy mode:** uses neighbouring trigger levels as the thresholds.
- **Band modes:** use a symmetric band of four or six characters.

Once armed, the pin goes high (pause) at the upper threshold. It returns low (send) only at the lower threshold. Between the two thresholds it keeps its state. The FIFO still accepts characters while paused, up to full.

Automatic pacing is enabled by a control bit. While it is off, or before it has been armed, the pin simply mirrors a host-written request bit. Arming happens once the host has driven the pin low with automatic mode enabled.

Top module: `auto_rts_hyst`

## Requirements
- R1: `trig_level` equals LVL0, LVL1, LVL2 or LVL3 for `trig_sel` 0, 1, 2 or 3. With the default parameters these are 8, 16, 24 and 28.
- R2: `rx_trig_irq` is high exactly when `rx_fill >= trig_level`, in the same cycle. The pin state has no effect on it.
- R3: With `hyst_sel` 00, `thr_off` is the next higher level (the highest level saturates at itself). `thr_on` is the next lower level, or 0 for the lowest level. Defaults: 8→16/0, 16→24/8, 24→28/16, 28→28/24.
- R4: With `hyst_sel` 01, `thr_off` = N+4 and `thr_on` = N−4.
- R5: With `hyst_sel` 10 or 11, `thr_off` = N+6 and `thr_on` = N−6.
- R6: Every computed threshold is clamped to the range 0 to DEPTH.
- R7: When armed, a cycle with `rx_fill >= thr_off` makes `rts_n` 1 from the next clock edge.
- R8: When armed, a cycle with `rx_fill <= thr_on` and `rx_fill < thr_off` makes `rts_n` 0 from the next edge.
- R9: When armed, with `rx_fill` strictly between the two thresholds, `rts_n` keeps its value.
- R10: While `auto_en` is 0, `rts_n` takes the inverse of `host_rts` at each edge, and the block is unarmed. With `auto_en` 1 and the block unarmed, `rts_n` likewise follows `~host_rts`. The block becomes armed at the edge where `host_rts` is 1.
- R11: During and right after reset, `rts_n` is 1 and the block is unarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_fill | input | CW | Receive FIFO occupancy, 0..DEPTH |
| trig_sel | input | 2 | Trigger level select |
| hyst_sel | input | 2 | Hysteresis mode select |
| auto_en | input | 1 | Automatic pacing enable |
| host_rts | input | 1 | Host request bit, 1 = assert (pin low) |
| rts_n | output | 1 | Active-low request-to-send pin |
| thr_off | output | CW | Upper threshold (pause at or above) |
| thr_on | output | CW | Lower threshold (resume at or below) |
| trig_level | output | CW | Selected interrupt level N |
| rx_trig_irq | output | 1 | Receive-trigger interrupt |

## Verification
The bench builds the block with DEPTH 32 and levels 2, 8, 16 and 30. At level 2 the ±4 and ±6 bands fall below zero. At level 30 they rise past the FIFO depth. Both clamping edges therefore come within reach, alongside unclamped mid-range cases. With DEPTH at 32 the fill walk also sweeps the whole count range, full included, in a few thousand cycles.

// File: rtl/ahr_pkg.sv
package ahr_pkg;
  typedef enum logic [1:0] {
    HY_LEGACY = 2'b00,
    HY_BAND4  = 2'b01,
    HY_BAND6A = 2'b10,
    HY_BAND6B = 2'b11
  } hyst_mode_e;

  function automatic int clamp_range(input int v, input int top);
    if (v < 0) return 0;
    if (v > top) return top;
    return v;
  endfunction
endpackage

// File: rtl/ahr_thresh.sv
module ahr_thresh import ahr_pkg::*; #(
  parameter int DEPTH = 128,
  parameter int LVL0  = 8,
  parameter int LVL1  = 16,
  parameter int LVL2  = 24,
  parameter int LVL3  = 28,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    trig_sel,
  input  logic [1:0]    hyst_sel,
  output logic [CW-1:0] trig_level,
  output logic [CW-1:0] thr_off,
  output logic [CW-1:0] thr_on
);
  localparam int NLV = 4;
  localparam int LV [NLV] = '{LVL0, LVL1, LVL2, LVL3};

  int n, hi, lo, idx;
  hyst_mode_e mode;

  always_comb begin
    idx  = int'(trig_sel);
    mode = hyst_mode_e'(hyst_sel);
    n    = LV[idx];
    unique case (mode)
      HY_LEGACY: begin
        hi = (idx == NLV - 1) ? LV[NLV - 1] : LV[(idx + 1) % NLV];
        lo = (idx == 0) ? 0 : LV[(idx + NLV - 1) % NLV];
      end
      HY_BAND4: begin
        hi = n + 4;
        lo = n - 4;
      end
      default: begin
        hi = n + 6;
        lo = n - 6;
      end
    endcase
    trig_level = CW'(clamp_range(n, DEPTH));
    thr_off    = CW'(clamp_range(hi, DEPTH));
    thr_on     = CW'(clamp_range(lo, DEPTH));
  end

  // R6: thresholds stay inside the FIFO range and keep their order
  p_thr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_off <= CW'(DEPTH)) && (thr_on <= thr_off));
endmodule

// File: rtl/ahr_trig.sv
module ahr_trig #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] rx_fill,
  input  logic [CW-1:0] trig_level,
  output logic          rx_trig_irq
);
  assign rx_trig_irq = (rx_fill >= trig_level);

  // R2: never asserted while below the level
  p_irq_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fill < trig_level) |-> !rx_trig_irq);
endmodule

// File: rtl/ahr_rts_ctrl.sv
module ahr_rts_ctrl #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] rx_fill,
  input  logic [CW-1:0] thr_off,
  input  logic [CW-1:0] thr_on,
  input  logic          auto_en,
  input  logic          host_rts,
  output logic          rts_n
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts_n <= 1'b1;
      armed <= 1'b0;
    end else if (!auto_en) begin
      rts_n <= ~host_rts;
      armed <= 1'b0;
    end else if (!armed) begin
      rts_n <= ~host_rts;
      armed <= host_rts;
    end else if (rx_fill >= thr_off) begin
      rts_n <= 1'b1;
    end else if (rx_fill <= thr_on) begin
      rts_n <= 1'b0;
    end
  end

  p_pause_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && armed && rx_fill >= thr_off) |=> rts_n);

  p_resume_lower_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && armed && rx_fill <= thr_on && rx_fill < thr_off) |=> !rts_n);

  p_hold_band_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && armed && rx_fill > thr_on && rx_fill < thr_off) |=> $stable(rts_n));

  p_manual_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en) |=> (rts_n == !$past(host_rts)));
endmodule

// File: rtl/auto_rts_hyst.sv
module auto_rts_hyst #(
  parameter int DEPTH = 128,
  parameter int LVL0  = 8,
  parameter int LVL1  = 16,
  parameter int LVL2  = 24,
  parameter int LVL3  = 28,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] rx_fill,
  input  logic [1:0]    trig_sel,
  input  logic [1:0]    hyst_sel,
  input  logic          auto_en,
  input  logic          host_rts,
  output logic          rts_n,
  output logic [CW-1:0] thr_off,
  output logic [CW-1:0] thr_on,
  output logic [CW-1:0] trig_level,
  output logic          rx_trig_irq
);
  ahr_thresh #(.DEPTH(DEPTH), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)) u_thresh (
    .clk(clk), .rst_n(rst_n), .trig_sel(trig_sel), .hyst_sel(hyst_sel),
    .trig_level(trig_level), .thr_off(thr_off), .thr_on(thr_on)
  );

  ahr_trig #(.CW(CW)) u_trig (
    .clk(clk), .rst_n(rst_n), .rx_fill(rx_fill), .trig_level(trig_level),
    .rx_trig_irq(rx_trig_irq)
  );

  ahr_rts_ctrl #(.CW(CW)) u_rts (
    .clk(clk), .rst_n(rst_n), .rx_fill(rx_fill), .thr_off(thr_off), .thr_on(thr_on),
    .auto_en(auto_en), .host_rts(host_rts), .rts_n(rts_n)
  );

  // R11: pin idles high straight out of reset
  p_reset_idle_r11: assert property (@(posedge clk) $rose(rst_n) |-> rts_n);
endmodule

// File: tb/auto_rts_hyst_tb.sv
module auto_rts_hyst_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int L0 = 2, L1 = 8, L2 = 16, L3 = 30;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] rx_fill = '0;
  logic [1:0] trig_sel = '0, hyst_sel = '0;
  logic auto_en = 0, host_rts = 0;
  logic rts_n, rx_trig_irq;
  logic [CW-1:0] thr_off, thr_on, trig_level;

  int total = 0, bad = 0;
  logic m_rts_n, m_armed;

  always #(CLK_PERIOD/2) clk = ~clk;

  auto_rts_hyst #(.DEPTH(DEPTH), .LVL0(L0), .LVL1(L1), .LVL2(L2), .LVL3(L3)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_fill(rx_fill), .trig_sel(trig_sel), .hyst_sel(hyst_sel),
    .auto_en(auto_en), .host_rts(host_rts), .rts_n(rts_n), .thr_off(thr_off),
    .thr_on(thr_on), .trig_level(trig_level), .rx_trig_irq(rx_trig_irq)
  );

  function automatic int lvl(input int s);
    case (s) 0: return L0; 1: return L1; 2: return L2; default: return L3; endcase
  endfunction
  function automatic int clp(input int v);
    return v < 0 ? 0 : (v > DEPTH ? DEPTH : v);
  endfunction
  function automatic int exp_off(input int s, input int h);
    if (h == 0) return clp(s == 3 ? L3 : lvl(s + 1));
    if (h == 1) return clp(lvl(s) + 4);
    return clp(lvl(s) + 6);
  endfunction
  function automatic int exp_on(input int s, input int h);
    if (h == 0) return clp(s == 0 ? 0 : lvl(s - 1));
    if (h == 1) return clp(lvl(s) - 4);
    return clp(lvl(s) - 6);
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  task automatic check_comb();
    int s, h;
    s = int'(trig_sel); h = int'(hyst_sel);
    chk("R1 trig_level", int'(trig_level), lvl(s));
    chk("R2 irq", int'(rx_trig_irq), (int'(rx_fill) >= lvl(s)) ? 1 : 0);
    if (h == 0) chk("R3 off", int'(thr_off), exp_off(s, h));
    else if (h == 1) chk("R4 off", int'(thr_off), exp_off(s, h));
    else chk("R5 off", int'(thr_off), exp_off(s, h));
    chk(h == 0 ? "R3 on" : (h == 1 ? "R4 on" : "R5 on"), int'(thr_on), exp_on(s, h));
  endtask

  // drive at negedge, check comb, clock, update model, check pin
  task automatic step(input int f, input int s, input int h, input bit ae, input bit hr);
    int off, on;
    string req;
    rx_fill = CW'(f); trig_sel = 2'(s); hyst_sel = 2'(h); auto_en = ae; host_rts = hr;
    #1;
    check_comb();
    off = exp_off(s, h); on = exp_on(s, h);
    req = "R10";
    if (!ae) begin m_rts_n = ~hr; m_armed = 0; end
    else if (!m_armed) begin m_rts_n = ~hr; m_armed = hr; end
    else if (f >= off) begin m_rts_n = 1; req = "R7"; end
    else if (f <= on) begin m_rts_n = 0; req = "R8"; end
    else req = "R9";
    @(posedge clk);
    @(negedge clk);
    chk(req, int'(rts_n), int'(m_rts_n));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int f, s, h;
    bit ae, hr;
    void'($urandom(32'd1234));
    m_rts_n = 1; m_armed = 0;
    repeat (3) @(negedge clk);
    chk("R11 rts_n in reset", int'(rts_n), 1);
    rst_n = 1;
    @(negedge clk);
    chk("R11 rts_n after reset", int'(rts_n), 1);
    // R6 clamp corners: level 2 low side, level 30 high side
    step(0, 0, 1, 0, 0); chk("R6 low clamp", int'(thr_on), 0);
    step(0, 3, 2, 0, 0); chk("R6 high clamp", int'(thr_off), DEPTH);
    step(0, 3, 0, 0, 0); chk("R3 top saturate", int'(thr_off), L3);
    // R10 unarmed follow, then arm
    step(20, 1, 1, 1, 0); chk("R10 unarmed pin", int'(rts_n), 1);
    step(20, 1, 1, 1, 1); chk("R10 armed low", int'(rts_n), 0);
    // band 8: off 12, on 4
    step(11, 1, 1, 1, 0); chk("R9 hold low", int'(rts_n), 0);
    step(12, 1, 1, 1, 0); chk("R7 pause", int'(rts_n), 1);
    step(32, 1, 1, 1, 0); chk("R7 full", int'(rts_n), 1);
    step(5, 1, 1, 1, 0);  chk("R9 hold high", int'(rts_n), 1);
    step(4, 1, 1, 1, 0);  chk("R8 resume", int'(rts_n), 0);
    step(20, 1, 1, 0, 1); chk("R10 manual", int'(rts_n), 0);
    step(20, 1, 1, 0, 0); chk("R10 manual off", int'(rts_n), 1);
    // random walk
    f = 0; s = 1; h = 0; ae = 1; hr = 1;
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 3) s = int'($urandom_range(0, 3));
      else if (r < 6) h = int'($urandom_range(0, 3));
      else if (r < 8) ae = ($urandom_range(0, 9) != 0);
      else if (r < 10) hr = $urandom_range(0, 1);
      else if (r < 12) f = int'($urandom_range(0, DEPTH));
      else f = clp(f + int'($urandom_range(0, 4)) - 2);
      step(f, s, h, ae, hr);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule